// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Dual-Port Memory

This block holds 4096 bits of storage that two ports reach independently. Port A and port B each have their own clock, enable, write enable, output reset, address, write data and read data, and no control is shared between them. The width of each port is a parameter taken from 1, 2, 4, 8 or 16 bits. The depth follows from the width, so each port always spans the whole 4096 bits.

Because the two widths are chosen separately, a word written through one port can be read back through the other at a different width. This makes the block a bus-width converter as well as a shared buffer. Each port's read data leaves a register that updates on that port's clock. If both ports write the same bit on a shared clock edge, the stored value of that bit is undefined, so users must keep such writes apart.

Top module: `mixed_width_dpram`

## Requirements
- R1: A port of width W (1, 2, 4, 8 or 16) has 4096/W words and an address of 12 - log2(W) bits. Every address reaches its own W bits, and writing every address of one port fills all 4096 bits.
- R2: Bit i of the word at address a on a port of width W is storage bit a*W + i. Data written at one width reads back through the other port at its own width with this bit placement.
- R3: A read with the port enabled, reset low and write enable low shows the addressed word on the read data after the next rising edge of that port's clock.
- R4: A write with the port enabled and reset low stores the data and also shows it on the port's read data after that edge.
- R5: While a port's enable is low, that port writes nothing and its read data holds its value.
- R6: Reset high with the port enabled clears the port's read data to zero on the edge and takes priority over the read and the write-through. Reset with the enable low has no effect.
- R7: Reset never alters the stored bits. A write presented together with reset is still stored.
- R8: On a rising edge shared by both clocks, a read by one port of bits that the other port writes on that edge returns the previous contents. The next read returns the new data.
- R9: Writes from both ports on the same edge to disjoint bits that share one 16-bit storage row both persist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock, rising edge |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous read-data reset |
| addr_a | input | 12 - log2(WIDTH_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock, rising edge |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous read-data reset |
| addr_b | input | 12 - log2(WIDTH_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
The bench instantiates all 25 width pairs and fills the memory through one port, then sweeps it through the other. A design that scaled addresses wrongly or reversed bit order inside a word would return shuffled or repeated words in this sweep. A port with a wrong depth would leave part of the storage unreached. Targeted cycles cover the following corner cases:
- A write while the port is disabled. A leaking enable would corrupt the word read afterwards.
- Reset together with a write. A reset that blocked the write, or one that cleared the storage, would show up on the read that follows.
- Reads that collide with a write from the other port on the same edge. These must return the old value on that edge and the new value one edge later.
- Writes by both ports to disjoint lanes of one row. A design that lost one of the two writes would fail here.

A randomized phase then mixes enables, resets, reads and non-overlapping writes from both ports.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    localparam int TOTAL_BITS = 4096;
    localparam int ROW_BITS   = 16;
    localparam int ROWS       = TOTAL_BITS / ROW_BITS;
    localparam int ROW_AW     = $clog2(ROWS);
    localparam int OFF_W      = $clog2(ROW_BITS);
    localparam int BIT_AW     = $clog2(TOTAL_BITS);

    typedef logic [ROW_AW-1:0]   row_idx_t;
    typedef logic [OFF_W-1:0]    row_off_t;
    typedef logic [ROW_BITS-1:0] row_bits_t;

    // One masked write into a single storage row.
    typedef struct packed {
        logic      en;
        row_idx_t  row;
        row_bits_t mask;
        row_bits_t bits;
    } row_write_t;

endpackage

// File: rtl/dpram_port_map.sv
// Maps a port address of width W onto a storage row and bit offset,
// and aligns the write data and mask into that row.
module dpram_port_map
    import dpram_pkg::*;
#(
    parameter int W = 8,
    localparam int SHIFT = $clog2(W),
    localparam int AW = BIT_AW - SHIFT
) (
    input  logic         en,
    input  logic         we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0] din,
    output row_write_t   wr,
    output row_idx_t     row,
    output row_off_t     off
);

    localparam row_bits_t LANE_ONES = row_bits_t'((32'd1 << W) - 32'd1);

    logic [BIT_AW-1:0] bit_idx;

    always_comb begin
        bit_idx = BIT_AW'(addr) << SHIFT;
        row     = bit_idx[BIT_AW-1:OFF_W];
        off     = bit_idx[OFF_W-1:0];
        wr.en   = en & we;
        wr.row  = row;
        wr.mask = LANE_ONES << off;
        wr.bits = row_bits_t'(din) << off;
    end

endmodule

// File: rtl/dpram_bank.sv
// One storage bank written from a single clock. The logical value of a
// bit is the XOR of this bank and the partner bank, so a write stores
// the new data XOR the partner's current bits.
module dpram_bank
    import dpram_pkg::*;
(
    input  logic       clk,
    input  row_write_t wr,
    input  row_bits_t  partner_bits,
    input  row_idx_t   rd_row_x,
    input  row_idx_t   rd_row_y,
    output row_bits_t  q_x,
    output row_bits_t  q_y
);

    row_bits_t mem [ROWS];
    row_bits_t row_d;

    always_comb begin
        row_d = (mem[wr.row] & ~wr.mask) | ((wr.bits ^ partner_bits) & wr.mask);
    end

    always_ff @(posedge clk) begin
        if (wr.en) begin
            mem[wr.row] <= row_d;
        end
    end

    assign q_x = mem[rd_row_x];
    assign q_y = mem[rd_row_y];

endmodule

// File: rtl/dpram_port_out.sv
// Registered read data of one port: reset, write-through and read.
module dpram_port_out
    import dpram_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         en,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] din,
    input  row_bits_t    row_val,
    input  row_off_t     off,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] dout;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (rst) begin
                st_d.dout = '0;
            end else if (we) begin
                st_d.dout = din;
            end else begin
                st_d.dout = W'(row_val >> off);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/mixed_width_dpram.sv
module mixed_width_dpram
    import dpram_pkg::*;
#(
    parameter int WIDTH_A = 8,
    parameter int WIDTH_B = 2,
    localparam int ADDR_A_W = BIT_AW - $clog2(WIDTH_A),
    localparam int ADDR_B_W = BIT_AW - $clog2(WIDTH_B)
) (
    input  logic                clk_a,
    input  logic                en_a,
    input  logic                we_a,
    input  logic                rst_a,
    input  logic [ADDR_A_W-1:0] addr_a,
    input  logic [WIDTH_A-1:0]  din_a,
    output logic [WIDTH_A-1:0]  dout_a,
    input  logic                clk_b,
    input  logic                en_b,
    input  logic                we_b,
    input  logic                rst_b,
    input  logic [ADDR_B_W-1:0] addr_b,
    input  logic [WIDTH_B-1:0]  din_b,
    output logic [WIDTH_B-1:0]  dout_b
);

    row_write_t wr_a, wr_b;
    row_idx_t   row_a, row_b;
    row_off_t   off_a, off_b;
    row_bits_t  bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
    row_bits_t  view_a, view_b;

    dpram_port_map #(.W(WIDTH_A)) u_map_a (
        .en(en_a), .we(we_a), .addr(addr_a), .din(din_a),
        .wr(wr_a), .row(row_a), .off(off_a)
    );

    dpram_port_map #(.W(WIDTH_B)) u_map_b (
        .en(en_b), .we(we_b), .addr(addr_b), .din(din_b),
        .wr(wr_b), .row(row_b), .off(off_b)
    );

    dpram_bank u_bank_a (
        .clk(clk_a), .wr(wr_a), .partner_bits(bank_b_at_a),
        .rd_row_x(row_a), .rd_row_y(row_b),
        .q_x(bank_a_at_a), .q_y(bank_a_at_b)
    );

    dpram_bank u_bank_b (
        .clk(clk_b), .wr(wr_b), .partner_bits(bank_a_at_b),
        .rd_row_x(row_a), .rd_row_y(row_b),
        .q_x(bank_b_at_a), .q_y(bank_b_at_b)
    );

    assign view_a = bank_a_at_a ^ bank_b_at_a;
    assign view_b = bank_a_at_b ^ bank_b_at_b;

    dpram_port_out #(.W(WIDTH_A)) u_out_a (
        .clk(clk_a), .en(en_a), .rst(rst_a), .we(we_a), .din(din_a),
        .row_val(view_a), .off(off_a), .dout(dout_a)
    );

    dpram_port_out #(.W(WIDTH_B)) u_out_b (
        .clk(clk_b), .en(en_b), .rst(rst_b), .we(we_b), .din(din_b),
        .row_val(view_b), .off(off_b), .dout(dout_b)
    );

endmodule

// File: rtl/dpram_checker.sv
module dpram_checker #(
    parameter int WIDTH_A = 8,
    parameter int WIDTH_B = 2
) (
    input logic               clk_a,
    input logic               en_a,
    input logic               we_a,
    input logic               rst_a,
    input logic [WIDTH_A-1:0] din_a,
    input logic [WIDTH_A-1:0] dout_a,
    input logic               clk_b,
    input logic               en_b,
    input logic               we_b,
    input logic               rst_b,
    input logic [WIDTH_B-1:0] din_b,
    input logic [WIDTH_B-1:0] dout_b
);

    // A port counts as initialised once it has seen an enabled reset.
    logic armed_a;
    logic armed_b;
    initial armed_a = 1'b0;
    initial armed_b = 1'b0;

    always @(posedge clk_a) if (en_a && rst_a) armed_a <= 1'b1;
    always @(posedge clk_b) if (en_b && rst_b) armed_b <= 1'b1;

    assert_reset_clears_R6_a: assert property (@(posedge clk_a) disable iff (!armed_a)
        (en_a && rst_a) |=> (dout_a == '0));
    assert_reset_clears_R6_b: assert property (@(posedge clk_b) disable iff (!armed_b)
        (en_b && rst_b) |=> (dout_b == '0));

    assert_disabled_holds_R5_a: assert property (@(posedge clk_a) disable iff (!armed_a)
        !en_a |=> $stable(dout_a));
    assert_disabled_holds_R5_b: assert property (@(posedge clk_b) disable iff (!armed_b)
        !en_b |=> $stable(dout_b));

    assert_write_through_R4_a: assert property (@(posedge clk_a) disable iff (!armed_a)
        (en_a && we_a && !rst_a) |=> (dout_a == $past(din_a)));
    assert_write_through_R4_b: assert property (@(posedge clk_b) disable iff (!armed_b)
        (en_b && we_b && !rst_b) |=> (dout_b == $past(din_b)));

endmodule

bind mixed_width_dpram dpram_checker #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_checker (
    .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .rst_a(rst_a), .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .rst_b(rst_b), .din_b(din_b), .dout_b(dout_b)
);

// File: tb/test_dpram_pair.sv
module test_dpram_pair #(
    parameter int WA = 1,
    parameter int WB = 1
) (
    input  logic clk,
    input  logic start,
    output logic done,
    output int   n_cmp,
    output int   n_bad
);

    localparam int TOTAL = 4096;
    localparam int DA    = TOTAL / WA;
    localparam int DB    = TOTAL / WB;
    localparam int AWA   = $clog2(DA);
    localparam int AWB   = $clog2(DB);

    logic           en_a, we_a, rst_a, en_b, we_b, rst_b;
    logic [AWA-1:0] addr_a;
    logic [AWB-1:0] addr_b;
    logic [WA-1:0]  din_a, dout_a, exp_a;
    logic [WB-1:0]  din_b, dout_b, exp_b;

    mixed_width_dpram #(.WIDTH_A(WA), .WIDTH_B(WB)) i_mixed_width_dpram (
        .clk_a(clk), .en_a(en_a), .we_a(we_a), .rst_a(rst_a),
        .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
        .clk_b(clk), .en_b(en_b), .we_b(we_b), .rst_b(rst_b),
        .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
    );

    bit ref_mem [TOTAL];

    function automatic logic [15:0] peek(int addr, int w);
        logic [15:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = ref_mem[addr * w + i];
        return r;
    endfunction

    task automatic poke(int addr, int w, logic [15:0] d);
        for (int i = 0; i < w; i++) ref_mem[addr * w + i] = d[i];
    endtask

    function automatic logic [15:0] pat(int a, int salt);
        return 16'((a * 40503) ^ salt);
    endfunction

    function automatic string tag_of(int e, int w, int r, string ph);
        if (e == 0) return (r != 0) ? "R6" : "R5";
        if (r != 0) return "R6";
        if (w != 0) return "R4";
        return ph;
    endfunction

    // One clock: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge.
    task automatic step(int ea, int wa, int ra, int aa, logic [15:0] da,
                        int eb, int wb, int rb, int ab, logic [15:0] db, string ph);
        string ta, tb_s;
        en_a = (ea != 0); we_a = (wa != 0); rst_a = (ra != 0);
        addr_a = AWA'(aa); din_a = WA'(da);
        en_b = (eb != 0); we_b = (wb != 0); rst_b = (rb != 0);
        addr_b = AWB'(ab); din_b = WB'(db);
        @(posedge clk);
        if (ea != 0) begin
            if (ra != 0)      exp_a = '0;
            else if (wa != 0) exp_a = WA'(da);
            else              exp_a = WA'(peek(aa, WA));
        end
        if (eb != 0) begin
            if (rb != 0)      exp_b = '0;
            else if (wb != 0) exp_b = WB'(db);
            else              exp_b = WB'(peek(ab, WB));
        end
        if (ea != 0 && wa != 0) poke(aa, WA, da);
        if (eb != 0 && wb != 0) poke(ab, WB, db);
        ta   = tag_of(ea, wa, ra, ph);
        tb_s = tag_of(eb, wb, rb, ph);
        @(negedge clk);
        n_cmp++;
        if (dout_a !== exp_a) begin
            n_bad++;
            $display("FAIL %s port A (WA=%0d WB=%0d addr %0d): got %h expected %h",
                     ta, WA, WB, aa, dout_a, exp_a);
        end
        n_cmp++;
        if (dout_b !== exp_b) begin
            n_bad++;
            $display("FAIL %s port B (WA=%0d WB=%0d addr %0d): got %h expected %h",
                     tb_s, WA, WB, ab, dout_b, exp_b);
        end
    endtask

    initial begin
        done = 1'b0; n_cmp = 0; n_bad = 0;
        en_a = 0; we_a = 0; rst_a = 0; addr_a = '0; din_a = '0;
        en_b = 0; we_b = 0; rst_b = 0; addr_b = '0; din_b = '0;
        exp_a = '0; exp_b = '0;
        wait (start);
        @(negedge clk);

        // R6: enabled reset on both ports
        step(1, 0, 1, 0, 0, 1, 0, 1, 0, 0, "R6");

        // R1 / R2: fill through A, sweep through B
        for (int a = 0; a < DA; a++) step(1, 1, 0, a, pat(a, 16'h5a5a), 0, 0, 0, 0, 0, "R1");
        for (int a = 0; a < DB; a++) step(0, 0, 0, 0, 0, 1, 0, 0, a, 0, "R2");
        // R2: fill through B, sweep through A
        for (int a = 0; a < DB; a++) step(0, 0, 0, 0, 0, 1, 1, 0, a, pat(a, 16'hc3a1), "R1");
        for (int a = 0; a < DA; a++) step(1, 0, 0, a, 0, 0, 0, 0, 0, 0, "R2");

        // R5: disabled write is dropped, then read back
        step(0, 1, 0, 3 % DA, 16'hffff, 0, 1, 0, 7 % DB, 16'hffff, "R5");
        step(1, 0, 0, 3 % DA, 0, 1, 0, 0, 7 % DB, 0, "R5");
        // R6: reset while disabled is ignored
        step(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, "R6");

        // R7: reset together with a write; the write still lands
        step(1, 1, 1, 5 % DA, 16'ha5c3, 0, 0, 0, 0, 0, "R7");
        step(1, 0, 0, 5 % DA, 0, 1, 0, 0, (5 * WA / WB) % DB, 0, "R7");
        step(1, 0, 1, 9 % DA, 0, 1, 0, 1, 0, 0, "R7");
        step(1, 0, 0, 9 % DA, 0, 0, 0, 0, 0, 0, "R7");

        // R8: B reads the word A overwrites on the same edge
        step(1, 1, 0, 12 % DA, 16'h3c96, 1, 0, 0, (12 * WA / WB) % DB, 0, "R8");
        step(0, 0, 0, 0, 0, 1, 0, 0, (12 * WA / WB) % DB, 0, "R8");
        step(1, 0, 0, (40 * WB / WA) % DA, 0, 1, 1, 0, 40 % DB, 16'h7e81, "R8");
        step(1, 0, 0, (40 * WB / WA) % DA, 0, 0, 0, 0, 0, 0, "R8");

        // R9: disjoint lanes of row 0 written on one edge
        if (WA + WB <= 16) begin
            step(1, 1, 0, 0, 16'h6b2d, 1, 1, 0, 16 / WB - 1, 16'hd4e9, "R9");
            step(1, 0, 0, 0, 0, 1, 0, 0, 16 / WB - 1, 0, "R9");
            step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R9");
        end

        // R3: randomized mix of both ports, overlapping writes avoided
        for (int n = 0; n < 400; n++) begin
            int ea, wa, ra, aa, eb, wb, rb, ab;
            ea = ($urandom % 4 != 0) ? 1 : 0;
            wa = int'($urandom % 2);
            ra = ($urandom % 8 == 0) ? 1 : 0;
            aa = int'($urandom % DA);
            eb = ($urandom % 4 != 0) ? 1 : 0;
            wb = int'($urandom % 2);
            rb = ($urandom % 8 == 0) ? 1 : 0;
            ab = int'($urandom % DB);
            if (ea != 0 && wa != 0 && eb != 0 && wb != 0 &&
                aa * WA < ab * WB + WB && ab * WB < aa * WA + WA) wb = 0;
            step(ea, wa, ra, aa, 16'($urandom), eb, wb, rb, ab, 16'($urandom), "R3");
        end

        done = 1'b1;
    end

endmodule

// File: tb/test_mixed_width_dpram.sv
module test_mixed_width_dpram;

    localparam int NW    = 5;
    localparam int NPAIR = NW * NW;
    localparam int LIMIT = 150000;

    logic             clk = 1'b0;
    logic             start = 1'b0;
    logic [NPAIR-1:0] done;
    int               cmp_v [NPAIR];
    int               bad_v [NPAIR];

    always #10 clk = ~clk;

    for (genvar i = 0; i < NW; i++) begin : g_wa
        for (genvar j = 0; j < NW; j++) begin : g_wb
            test_dpram_pair #(.WA(1 << i), .WB(1 << j)) u_pair (
                .clk(clk), .start(start), .done(done[i * NW + j]),
                .n_cmp(cmp_v[i * NW + j]), .n_bad(bad_v[i * NW + j])
            );
        end
    end

    initial begin
        int cycles = 0;
        int total_cmp = 0;
        int total_bad = 0;
        repeat (3) @(posedge clk);
        start = 1'b1;
        while (!(&done) && cycles < LIMIT) begin
            @(posedge clk);
            cycles++;
        end
        @(negedge clk);
        for (int k = 0; k < NPAIR; k++) begin
            total_cmp += cmp_v[k];
            total_bad += bad_v[k];
        end
        if (!(&done)) begin
            total_cmp++;
            total_bad++;
            $display("FAIL watchdog: pairs done %b, expected all ones", done);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total_cmp, total_bad);
        $finish;
    end

endmodule